// File: doc/BRIEF.md
# FM Channel Seek and Tune Sequencer

This block is the control engine that moves a receiver across an FM band. A direct tune loads a programmed channel code at once. A seek steps the channel code through the selected band one spacing at a time. For each candidate it asks an external quality source for a measurement, and it stops at the first candidate whose returned quality reaches the threshold. The channel code maps to frequency as 64 MHz + 50 kHz × code. The synthesizer and the metric computation sit outside the block. They are reached through a request/valid handshake: `meas_req` is held high while the candidate on `chan_out` is being judged.

When the search runs out, one of two policies applies. In wrap mode the search wraps around the band and, after one full pass, gives up at the channel it started from. In edge-stop mode it parks at the band edge it ran into. Either way a sticky completion flag, a fail flag, a mute output and a level-selectable interrupt report the outcome. Band, spacing, direction and mode are captured when a seek starts. The threshold and auto-tune inputs are read live.

Top module: `seek_tune_seq`

## Requirements
- R1: After a synchronous reset, `chan_out` is 0x1CC, and `busy`, `stc`, `fail_flag`, `audio_mute`, `irq` and `meas_req` are all 0.
- R2: Band code `band_sel` selects the channel code limits: 0 → 460..880, 1 → 240..880, 2 → 240..520, 3 (reserved) → same as 0. Every candidate presented with `meas_req` high lies inside these limits.
- R3: Spacing code `space_sel` selects the step in channel codes: 0 → 4, 1 → 2, 2 → 1, 3 (reserved) → 4.
- R4: A `tune_go` pulse while idle loads `chan_cfg` into `chan_out` and sets `stc`, clears `fail_flag` and clears `audio_mute` on the next clock. A `tune_go` pulse takes priority over `seek_go`. Both pulses are ignored while `busy`.
- R5: A seek moves up when `seek_up`=1 and down when it is 0. Each candidate is placed on `chan_out` together with `meas_req`, and `meas_req` drops after the clock that samples `meas_valid`. A candidate qualifies when `meas_quality` ≥ `qual_thr`, which ends the seek with `fail_flag`=0.
- R6: When the start channel lies outside the band on the side the seek moves away from, the first candidate is clamped to the near band edge.
- R7: With `edge_stop`=0, a step past the top edge wraps to the bottom edge, and a step past the bottom edge wraps to the top edge. Once wrapped, reaching or crossing the start channel, or needing a second wrap, ends the seek at the start channel with `fail_flag`=1.
- R8: With `edge_stop`=1, a step that would leave the band ends the seek with `chan_out` at that edge and `fail_flag`=1.
- R9: `audio_mute` is 1 throughout a seek. At the end of the seek it becomes the inverse of `auto_tune`, and with `auto_tune`=0 it stays 1 until a tune.
- R10: `stc` goes to 0 when a seek starts and to 1 when the seek or a tune completes. It then holds until an `stc_clr` pulse while idle.
- R11: `irq` is registered: one clock after `int_en && stc` it shows that condition at the level set by `int_high` (1 = active high). Otherwise it shows the opposite level.
- R12: `busy` is 1 from the clock after `seek_go` until the seek ends, and `chan_out` shows the current candidate throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_go | input | 1 | Direct tune request pulse |
| seek_go | input | 1 | Seek start pulse |
| stc_clr | input | 1 | Software clear of completion flag |
| seek_up | input | 1 | Seek direction, 1 = up |
| edge_stop | input | 1 | 1 = stop at band edge, 0 = wrap |
| auto_tune | input | 1 | Unmute on seek completion |
| band_sel | input | 2 | Band code |
| space_sel | input | 2 | Spacing code |
| chan_cfg | input | 10 | Channel code for direct tune |
| qual_thr | input | 8 | Qualification threshold |
| int_en | input | 1 | Interrupt enable |
| int_high | input | 1 | Interrupt active level, 1 = high |
| meas_req | output | 1 | Measurement request for `chan_out` |
| meas_valid | input | 1 | Measurement result valid |
| meas_quality | input | 8 | Measured quality |
| chan_out | output | 10 | Current channel code |
| busy | output | 1 | Seek in progress |
| stc | output | 1 | Seek/tune complete flag |
| fail_flag | output | 1 | Seek failed or stopped at band limit |
| audio_mute | output | 1 | Audio muted |
| irq | output | 1 | Completion interrupt |

## Verification
The embedded properties watch, on every cycle, the invariants that hold regardless of the stimulus: a request is raised only during a seek and only for an in-band candidate, audio is muted while busy, the completion flag is set as `busy` falls and then stays sticky, and edge-stop failures end on a band limit. The bench scenarios alone show the behaviours that depend on the path taken: the exact sequence of candidates, wrap-around and return to the start channel after a full pass, clamping of an out-of-band start, the reserved-code fallbacks, auto-tune muting, and the interrupt polarity.

// File: rtl/seek_pkg.sv
package seek_pkg;
  localparam int CH_W = 10;
  localparam int Q_W  = 8;

  // channel code for a frequency in kHz (64 MHz origin, 50 kHz grain)
  function automatic int khz_to_ch(input int khz);
    return (khz - 64000) / 50;
  endfunction

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_STEP = 2'd1,
    S_MEAS = 2'd2
  } seq_state_t;
endpackage

// File: rtl/band_decode.sv
module band_decode #(
  parameter int CH_W = seek_pkg::CH_W
) (
  input  logic [1:0]      band,
  input  logic [1:0]      space,
  output logic [CH_W-1:0] lo,
  output logic [CH_W-1:0] hi,
  output logic [CH_W-1:0] step
);
  localparam logic [CH_W-1:0] CH_87  = CH_W'(seek_pkg::khz_to_ch(87000));
  localparam logic [CH_W-1:0] CH_76  = CH_W'(seek_pkg::khz_to_ch(76000));
  localparam logic [CH_W-1:0] CH_90  = CH_W'(seek_pkg::khz_to_ch(90000));
  localparam logic [CH_W-1:0] CH_108 = CH_W'(seek_pkg::khz_to_ch(108000));
  localparam logic [CH_W-1:0] ST_200 = CH_W'(4);
  localparam logic [CH_W-1:0] ST_100 = CH_W'(2);
  localparam logic [CH_W-1:0] ST_50  = CH_W'(1);

  always_comb begin
    unique case (band)
      2'd1:    begin lo = CH_76; hi = CH_108; end
      2'd2:    begin lo = CH_76; hi = CH_90;  end
      default: begin lo = CH_87; hi = CH_108; end  // 0 and reserved 3
    endcase
    unique case (space)
      2'd1:    step = ST_100;
      2'd2:    step = ST_50;
      default: step = ST_200;                      // 0 and reserved 3
    endcase
  end
endmodule

// File: rtl/step_calc.sv
module step_calc #(
  parameter int CH_W = seek_pkg::CH_W
) (
  input  logic [CH_W-1:0] cur,
  input  logic [CH_W-1:0] start,
  input  logic [CH_W-1:0] lo,
  input  logic [CH_W-1:0] hi,
  input  logic [CH_W-1:0] step,
  input  logic            up,
  input  logic            edge_stop,
  input  logic            wrapped,
  output logic [CH_W-1:0] cand,
  output logic            wrap_now,
  output logic            end_fail,
  output logic [CH_W-1:0] end_ch
);
  localparam int XW = CH_W + 2;
  logic signed [XW-1:0] raw, lo_s, hi_s;

  always_comb begin
    lo_s = $signed({2'b00, lo});
    hi_s = $signed({2'b00, hi});
    raw  = up ? $signed({2'b00, cur}) + $signed({2'b00, step})
              : $signed({2'b00, cur}) - $signed({2'b00, step});
    cand     = cur;
    wrap_now = 1'b0;
    end_fail = 1'b0;
    end_ch   = cur;
    if (up) begin
      if (raw > hi_s) begin
        if (edge_stop)    begin end_fail = 1'b1; end_ch = hi;    end
        else if (wrapped) begin end_fail = 1'b1; end_ch = start; end
        else              begin cand = lo; wrap_now = 1'b1;      end
      end else if (raw < lo_s) cand = lo;
      else                     cand = raw[CH_W-1:0];
    end else begin
      if (raw < lo_s) begin
        if (edge_stop)    begin end_fail = 1'b1; end_ch = lo;    end
        else if (wrapped) begin end_fail = 1'b1; end_ch = start; end
        else              begin cand = hi; wrap_now = 1'b1;      end
      end else if (raw > hi_s) cand = hi;
      else                     cand = raw[CH_W-1:0];
    end
    // full pass: back at or beyond the start after a wrap
    if (!end_fail && (wrapped || wrap_now) &&
        (up ? (cand >= start) : (cand <= start))) begin
      end_fail = 1'b1;
      end_ch   = start;
    end
  end
endmodule

// File: rtl/irq_level.sv
module irq_level (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic flag,
  input  logic active_high,
  output logic irq
);
  logic act;
  assign act = enable & flag;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= active_high ? act : ~act;
  end
endmodule

// File: rtl/seek_tune_seq.sv
module seek_tune_seq #(
  parameter int CH_W = seek_pkg::CH_W,
  parameter int Q_W  = seek_pkg::Q_W,
  parameter logic [CH_W-1:0] RST_CH = CH_W'(10'h1CC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tune_go,
  input  logic            seek_go,
  input  logic            stc_clr,
  input  logic            seek_up,
  input  logic            edge_stop,
  input  logic            auto_tune,
  input  logic [1:0]      band_sel,
  input  logic [1:0]      space_sel,
  input  logic [CH_W-1:0] chan_cfg,
  input  logic [Q_W-1:0]  qual_thr,
  input  logic            int_en,
  input  logic            int_high,
  output logic            meas_req,
  input  logic            meas_valid,
  input  logic [Q_W-1:0]  meas_quality,
  output logic [CH_W-1:0] chan_out,
  output logic            busy,
  output logic            stc,
  output logic            fail_flag,
  output logic            audio_mute,
  output logic            irq
);
  import seek_pkg::*;

  seq_state_t      state;
  logic [CH_W-1:0] start_q;
  logic [1:0]      band_q, space_q;
  logic            up_q, stop_q, wrapped_q;

  logic [CH_W-1:0] lo, hi, step, cand, end_ch;
  logic            wrap_now, end_fail;

  band_decode #(.CH_W(CH_W)) u_band (
    .band(band_q), .space(space_q), .lo(lo), .hi(hi), .step(step)
  );

  step_calc #(.CH_W(CH_W)) u_step (
    .cur(chan_out), .start(start_q), .lo(lo), .hi(hi), .step(step),
    .up(up_q), .edge_stop(stop_q), .wrapped(wrapped_q),
    .cand(cand), .wrap_now(wrap_now), .end_fail(end_fail), .end_ch(end_ch)
  );

  irq_level u_irq (
    .clk(clk), .rst(rst), .enable(int_en), .flag(stc),
    .active_high(int_high), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      chan_out   <= RST_CH;
      start_q    <= RST_CH;
      band_q     <= 2'd0;
      space_q    <= 2'd0;
      up_q       <= 1'b0;
      stop_q     <= 1'b0;
      wrapped_q  <= 1'b0;
      meas_req   <= 1'b0;
      busy       <= 1'b0;
      stc        <= 1'b0;
      fail_flag  <= 1'b0;
      audio_mute <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (tune_go) begin
            chan_out   <= chan_cfg;
            stc        <= 1'b1;
            fail_flag  <= 1'b0;
            audio_mute <= 1'b0;
          end else if (seek_go) begin
            start_q    <= chan_out;
            band_q     <= band_sel;
            space_q    <= space_sel;
            up_q       <= seek_up;
            stop_q     <= edge_stop;
            wrapped_q  <= 1'b0;
            busy       <= 1'b1;
            stc        <= 1'b0;
            fail_flag  <= 1'b0;
            audio_mute <= 1'b1;
            state      <= S_STEP;
          end else if (stc_clr) begin
            stc <= 1'b0;
          end
        end
        S_STEP: begin
          if (end_fail) begin
            chan_out   <= end_ch;
            busy       <= 1'b0;
            stc        <= 1'b1;
            fail_flag  <= 1'b1;
            audio_mute <= ~auto_tune;
            state      <= S_IDLE;
          end else begin
            chan_out  <= cand;
            wrapped_q <= wrapped_q | wrap_now;
            meas_req  <= 1'b1;
            state     <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (meas_valid) begin
            meas_req <= 1'b0;
            if (meas_quality >= qual_thr) begin
              busy       <= 1'b0;
              stc        <= 1'b1;
              fail_flag  <= 1'b0;
              audio_mute <= ~auto_tune;
              state      <= S_IDLE;
            end else begin
              state <= S_STEP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: measurement requests only while a seek runs
  p_req_in_seek_r5: assert property (@(posedge clk) disable iff (rst)
    meas_req |-> busy);
  // R2: every measured candidate sits inside the decoded band
  p_cand_in_band_r2: assert property (@(posedge clk) disable iff (rst)
    meas_req |-> (chan_out >= lo && chan_out <= hi));
  // R9: audio muted for the whole seek
  p_mute_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> audio_mute);
  // R10: completion flagged as the seek ends
  p_done_sets_stc_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> stc);
  // R10: flag is sticky until cleared or a new seek
  p_stc_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (stc && !stc_clr && !seek_go) |=> stc);
  // R8: an edge-stop failure parks on a band limit
  p_edge_park_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && fail_flag && stop_q) |-> (chan_out == lo || chan_out == hi));
endmodule

// File: tb/seek_tune_seq_test.sv
`timescale 1ns/1ps
module seek_tune_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tune_go = 0, seek_go = 0, stc_clr = 0, seek_up = 0, edge_stop = 0;
  logic auto_tune = 1, int_en = 0, int_high = 1, meas_valid = 0;
  logic [1:0] band_sel = 0, space_sel = 0;
  logic [9:0] chan_cfg = 0;
  logic [7:0] qual_thr = 8'd100, meas_quality = 0;
  logic meas_req, busy, stc, fail_flag, audio_mute, irq;
  logic [9:0] chan_out;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  seek_tune_seq uut (
    .clk(clk), .rst(rst), .tune_go(tune_go), .seek_go(seek_go), .stc_clr(stc_clr),
    .seek_up(seek_up), .edge_stop(edge_stop), .auto_tune(auto_tune),
    .band_sel(band_sel), .space_sel(space_sel), .chan_cfg(chan_cfg),
    .qual_thr(qual_thr), .int_en(int_en), .int_high(int_high),
    .meas_req(meas_req), .meas_valid(meas_valid), .meas_quality(meas_quality),
    .chan_out(chan_out), .busy(busy), .stc(stc), .fail_flag(fail_flag),
    .audio_mute(audio_mute), .irq(irq)
  );

  function automatic int qual_of(int ch);
    return (ch == 300 || ch == 500 || ch == 700) ? 200 : 10;
  endfunction
  function automatic int band_lo(int b);   return (b == 1 || b == 2) ? 240 : 460; endfunction
  function automatic int band_hi(int b);   return (b == 2) ? 520 : 880;           endfunction
  function automatic int step_of(int s);   return (s == 1) ? 2 : (s == 2) ? 1 : 4; endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // quality source: answers two negedges after a request
  int resp_cnt = 0;
  bit resp_pend = 0;
  always @(negedge clk) begin
    if (meas_valid) meas_valid <= 1'b0;
    else if (resp_pend) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        meas_valid   <= 1'b1;
        meas_quality <= 8'(qual_of(int'(chan_out)));
        resp_pend    = 0;
      end
    end else if (meas_req) begin
      resp_pend = 1;
      resp_cnt  = 2;
    end
  end

  // behavioural reference
  int m_ch, m_start, m_lo, m_hi, m_step, m_ph;
  bit m_up, m_stop, m_wr, m_busy, m_stc, m_fail, m_mute, m_irq, m_req;

  task automatic m_finish(bit f, int ch);
    m_ch = ch; m_busy = 0; m_stc = 1; m_fail = f; m_mute = !auto_tune; m_ph = 0;
  endtask

  always @(posedge clk) begin
    bit nirq;
    int nx;
    bit done;
    if (rst) begin
      m_ch = 'h1CC; m_ph = 0; m_busy = 0; m_stc = 0; m_fail = 0;
      m_mute = 0; m_irq = 0; m_req = 0; m_start = 'h1CC; m_wr = 0;
    end else begin
      nirq = int_high ? (int_en && m_stc) : !(int_en && m_stc);
      if (m_ph == 0) begin
        if (tune_go) begin
          m_ch = chan_cfg; m_stc = 1; m_fail = 0; m_mute = 0;
        end else if (seek_go) begin
          m_start = m_ch; m_lo = band_lo(band_sel); m_hi = band_hi(band_sel);
          m_step = step_of(space_sel); m_up = seek_up; m_stop = edge_stop;
          m_wr = 0; m_busy = 1; m_stc = 0; m_fail = 0; m_mute = 1; m_ph = 1;
        end else if (stc_clr) m_stc = 0;
      end else if (m_ph == 1) begin
        done = 0;
        nx = m_up ? m_ch + m_step : m_ch - m_step;
        if (m_up && nx > m_hi) begin
          if (m_stop) begin m_finish(1, m_hi); done = 1; end
          else if (m_wr) begin m_finish(1, m_start); done = 1; end
          else begin nx = m_lo; m_wr = 1; end
        end else if (!m_up && nx < m_lo) begin
          if (m_stop) begin m_finish(1, m_lo); done = 1; end
          else if (m_wr) begin m_finish(1, m_start); done = 1; end
          else begin nx = m_hi; m_wr = 1; end
        end else if (m_up && nx < m_lo) nx = m_lo;
        else if (!m_up && nx > m_hi) nx = m_hi;
        if (!done && m_wr && (m_up ? nx >= m_start : nx <= m_start)) begin
          m_finish(1, m_start); done = 1;
        end
        if (!done) begin m_ch = nx; m_req = 1; m_ph = 2; end
      end else begin
        if (meas_valid) begin
          m_req = 0;
          if (meas_quality >= qual_thr) m_finish(0, m_ch);
          else m_ph = 1;
        end
      end
      m_irq = nirq;
    end
    #2;
    if (!rst) begin
      check("R5/R12 chan_out", int'(chan_out), m_ch);
      check("R5 meas_req", int'(meas_req), int'(m_req));
      check("R12 busy", int'(busy), int'(m_busy));
      check("R10 stc", int'(stc), int'(m_stc));
      check("R7/R8 fail_flag", int'(fail_flag), int'(m_fail));
      check("R9 audio_mute", int'(audio_mute), int'(m_mute));
      check("R11 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic do_tune(int ch);
    @(negedge clk); chan_cfg = 10'(ch); tune_go = 1;
    @(negedge clk); tune_go = 0;
  endtask

  task automatic do_seek(bit up, int b, int s, bit stp, int inject);
    @(negedge clk);
    seek_up = up; band_sel = 2'(b); space_sel = 2'(s); edge_stop = stp; seek_go = 1;
    @(negedge clk); seek_go = 0;
    for (int i = 0; busy && i < 20000; i++) begin
      if (i == 5 && inject != 0) begin
        chan_cfg = 10'(inject); tune_go = 1; seek_go = 1;  // R4: ignored while busy
      end else begin
        tune_go = 0; seek_go = 0;
      end
      @(negedge clk);
    end
    tune_go = 0; seek_go = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 chan_out", int'(chan_out), 'h1CC);
    check("R1 busy", int'(busy), 0);
    check("R1 stc", int'(stc), 0);
    check("R1 fail_flag", int'(fail_flag), 0);
    check("R1 audio_mute", int'(audio_mute), 0);
    check("R1 meas_req", int'(meas_req), 0);
    check("R1 irq", int'(irq), 0);

    do_tune(600);                                     // R4
    check("R4 tune chan", int'(chan_out), 600);
    check("R4 tune stc", int'(stc), 1);

    do_seek(1, 0, 0, 0, 123);                          // R5 up, R4 ignore
    check("R5 seek up found", int'(chan_out), 700);
    check("R5 seek up pass", int'(fail_flag), 0);

    int_en = 1; int_high = 0;
    do_seek(0, 0, 1, 0, 0);                            // R3 spacing 2, down
    check("R3 down step 2", int'(chan_out), 500);
    @(negedge clk);
    check("R11 active low", int'(irq), 0);
    stc_clr = 1; @(negedge clk); stc_clr = 0;
    check("R10 cleared", int'(stc), 0);
    @(negedge clk);
    check("R11 idle high", int'(irq), 1);
    int_high = 1;

    do_seek(1, 2, 0, 1, 0);                            // R8 edge stop top
    check("R8 park hi", int'(chan_out), 520);
    check("R8 fail", int'(fail_flag), 1);

    do_tune(600);
    qual_thr = 8'd250;
    do_seek(1, 0, 0, 0, 0);                            // R7 full pass
    check("R7 return start", int'(chan_out), 600);
    check("R7 fail", int'(fail_flag), 1);
    qual_thr = 8'd100;

    do_tune(900);
    do_seek(0, 2, 2, 0, 0);                            // R6 clamp from above
    check("R6 clamp found", int'(chan_out), 500);

    do_tune(250);
    do_seek(0, 1, 2, 1, 0);                            // R8 edge stop bottom
    check("R8 park lo", int'(chan_out), 240);

    do_tune(460);
    do_seek(1, 3, 3, 0, 0);                            // R2/R3 reserved codes
    check("R2 reserved band/space", int'(chan_out), 500);

    auto_tune = 0;
    do_seek(1, 0, 0, 0, 0);                            // R9 stays muted
    check("R9 muted after seek", int'(audio_mute), 1);
    do_tune(700);
    check("R9 unmuted by tune", int'(audio_mute), 0);
    auto_tune = 1;

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule